// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds the time of day and the calendar date as packed-BCD registers. It advances them once per second. A reference-rate enable, `ref_tick_i`, drives an internal sub-second divider. The divider produces one advance for every `DIV_COUNT` enables and a 1 Hz square-wave phase. The counter covers seconds, minutes, hours, day of week, date, month and a two-digit year, plus a century flag kept in the month byte. The hour byte can use either a 12-hour or a 24-hour encoding. The date wraps at each month's real length, and February has 29 days in leap years.

A host sets the time through a write port that carries an address and a data byte. Each accepted byte appears on the outputs in the next cycle. A write takes priority over a second advance that falls in the same cycle. Writing the seconds register restarts the sub-second divider, so the next advance comes exactly one full second after that write. Alarm logic next to this block watches `sec_strobe_o`. That one-cycle pulse marks the cycle in which freshly advanced values first appear.

The write port uses valid/ready. The block never applies back-pressure: `wr_ready_o` stays high, and every cycle with `wr_valid_i` high transfers one byte. The port has no read path. The registers are always visible on the outputs.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs read 00 seconds, 00 minutes, hour 0x00 (24-hour mode, midnight), day of week 1, date 0x01, month 0x01 with century clear, and year 0x00. `sec_strobe_o` and `sqw_1hz_o` are low.
- R2: Seconds and minutes are packed BCD running 0x00 to 0x59. Seconds wrap from 0x59 to 0x00 and step the minutes. Minutes wrap the same way and step the hour.
- R3: With hour bit 6 clear (24-hour mode), bits 5:0 hold BCD 0x00 to 0x23. The hour wraps from 0x23 to 0x00, and that step starts a new day.
- R4: With hour bit 6 set (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 1 to 12. The sequence runs 11 AM (0x51) to 12 PM (0x72) to 1 PM (0x61), and 11 PM (0x71) to 12 AM (0x52). A new day starts only on the 11 PM to 12 AM step.
- R5: Day of week (1 to 7) steps at the start of each new day and wraps from 7 to 1.
- R6: Date (BCD 0x01 to 0x31) wraps to 0x01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 and 28 otherwise. All other months have 31 days.
- R7: The month byte holds BCD 0x01 to 0x12 in bits 4:0 and the century flag in bit 7. Month 0x12 wraps to 0x01 and steps the BCD year. The year wrap from 0x99 to 0x00 toggles the century flag.
- R8: A write with `wr_valid_i` high stores `wr_data_i` into register 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 date, 5 month, 6 year. The stored byte is masked to 0x7F, 0x7F, 0x7F, 0x07, 0x3F, 0x9F and 0xFF respectively, and shows on the outputs in the next cycle. A write to address 7 changes nothing.
- R9: A write to addresses 0 to 6 in the cycle where a second would end wins. That second is dropped: no register advances and no strobe is raised.
- R10: A seconds write restarts the divider. With `ref_tick_i` high every cycle, the next advance shows `DIV_COUNT` cycles after the first cycle in which the written value is visible.
- R11: `sqw_1hz_o` is low for the first `DIV_COUNT/2` reference enables of each second and high for the rest. It is therefore low right after a seconds write and rises `DIV_COUNT/2` enables later.
- R12: `sec_strobe_o` is high for exactly the one cycle in which advanced values first appear. Without a write or a strobe, the time and date outputs hold.
- R13: `wr_ready_o` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | Reference-rate enable feeding the sub-second divider |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write accept, always high |
| wr_addr_i | input | ADDR_W | Register address, 0 to 6 mapped |
| wr_data_i | input | 8 | Write data byte |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Hour with mode and AM/PM bits |
| dow_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month, bit 7 century |
| year_o | output | 8 | BCD year |
| sec_strobe_o | output | 1 | One-cycle pulse on each advance |
| sqw_1hz_o | output | 1 | 1 Hz square-wave phase |

## Verification
Every output is registered, so a wrong carry or month-length decision shows up at the ports in the cycle that follows the advance that went wrong. A bad wrap condition, for example, leaves an illegal BCD value or a date that should have wrapped, and it stays wrong from then on. Faults in the divider surface as a changed spacing between strobes, or as a square-wave edge at the wrong point after a seconds write. Each of these appears within one second of reference enables. The bench walks through month ends, leap and non-leap Februaries, the century wrap, and both hour encodings. It places writes exactly on the cycle where a second ends.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NUM_REGS    = 7;
  localparam int SEXA_FIELDS = 2;
  localparam int A_SECS = 0;
  localparam int A_MINS = 1;
  localparam int A_HRS  = 2;
  localparam int A_DOW  = 3;
  localparam int A_DATE = 4;
  localparam int A_MON  = 5;
  localparam int A_YR   = 6;

  typedef struct packed {
    logic [7:0] secs;
    logic [7:0] mins;
    logic [7:0] hrs;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{secs: 8'h00, mins: 8'h00, hrs: 8'h00,
                                       dow: 8'h01, date: 8'h01, mon: 8'h01, yr: 8'h00};

  // next packed-BCD value, lower digit carrying into upper
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] write_mask(input int idx);
    case (idx)
      A_SECS, A_MINS, A_HRS: write_mask = 8'h7F;
      A_DOW:                 write_mask = 8'h07;
      A_DATE:                write_mask = 8'h3F;
      A_MON:                 write_mask = 8'h9F;
      default:               write_mask = 8'hFF;
    endcase
  endfunction

  // last valid BCD date of a month; year multiple of 4 means leap
  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    logic [4:0] mod_sum;
    logic       leap;
    mod_sum = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    leap    = (mod_sum[1:0] == 2'b00);
    case (mon[4:0])
      5'h02:                      last_date = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick_i,
  input  logic restart_i,
  output logic sec_end_o,
  output logic phase_hi_o
);
  localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV_COUNT / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (ref_tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign sec_end_o  = ref_tick_i && (cnt_q == LAST);
  assign phase_hi_o = (cnt_q >= HALF);
endmodule

// File: rtl/rtc_time_advance.sv
`timescale 1ns/1ps
module rtc_time_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  output rtc_time_t nxt_o
);
  logic [SEXA_FIELDS-1:0][7:0] sx_cur;
  logic [SEXA_FIELDS-1:0][7:0] sx_nxt;
  logic [SEXA_FIELDS-1:0]      sx_wrap;

  assign sx_cur = {cur_i.mins, cur_i.secs};

  for (genvar g = 0; g < SEXA_FIELDS; g++) begin : g_sexa
    logic cin;
    if (g == 0) begin : g_first
      assign cin = 1'b1;
    end else begin : g_rest
      assign cin = &sx_wrap[g-1:0];
    end
    assign sx_wrap[g] = (sx_cur[g] == 8'h59);
    assign sx_nxt[g]  = !cin ? sx_cur[g] : (sx_wrap[g] ? 8'h00 : bcd_inc(sx_cur[g]));
  end

  logic       hour_step, day_step, mon_step, yr_step;
  logic [7:0] hr_n, dow_n, date_n, yr_n, h12_inc;
  logic [4:0] mon_lo_n;
  logic       cent_n;

  assign hour_step = &sx_wrap;
  assign h12_inc   = bcd_inc({3'b000, cur_i.hrs[4:0]});

  always_comb begin
    hr_n     = cur_i.hrs;
    day_step = 1'b0;
    if (hour_step) begin
      if (cur_i.hrs[6]) begin
        if (cur_i.hrs[4:0] == 5'h11) begin
          hr_n     = {cur_i.hrs[7:6], ~cur_i.hrs[5], 5'h12};
          day_step = cur_i.hrs[5];
        end else if (cur_i.hrs[4:0] == 5'h12) begin
          hr_n = {cur_i.hrs[7:5], 5'h01};
        end else begin
          hr_n = {cur_i.hrs[7:5], h12_inc[4:0]};
        end
      end else if (cur_i.hrs == 8'h23) begin
        hr_n     = 8'h00;
        day_step = 1'b1;
      end else begin
        hr_n = bcd_inc(cur_i.hrs);
      end
    end
  end

  always_comb begin
    dow_n    = cur_i.dow;
    date_n   = cur_i.date;
    mon_step = 1'b0;
    if (day_step) begin
      dow_n = (cur_i.dow == 8'd7) ? 8'd1 : cur_i.dow + 8'd1;
      if (cur_i.date == last_date(cur_i.mon, cur_i.yr)) begin
        date_n   = 8'h01;
        mon_step = 1'b1;
      end else begin
        date_n = bcd_inc(cur_i.date);
      end
    end
  end

  always_comb begin
    mon_lo_n = cur_i.mon[4:0];
    yr_n     = cur_i.yr;
    cent_n   = cur_i.mon[7];
    yr_step  = 1'b0;
    if (mon_step) begin
      if (cur_i.mon[4:0] == 5'h12) begin
        mon_lo_n = 5'h01;
        yr_step  = 1'b1;
      end else begin
        mon_lo_n = cur_i.mon[4:0] + ((cur_i.mon[3:0] == 4'd9) ? 5'd7 : 5'd1);
      end
    end
    if (yr_step) begin
      if (cur_i.yr == 8'h99) begin
        yr_n   = 8'h00;
        cent_n = ~cur_i.mon[7];
      end else begin
        yr_n = bcd_inc(cur_i.yr);
      end
    end
  end

  assign nxt_o = '{secs: sx_nxt[0], mins: sx_nxt[1], hrs: hr_n, dow: dow_n,
                   date: date_n, mon: {cent_n, cur_i.mon[6:5], mon_lo_n}, yr: yr_n};
endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_COUNT = 32768,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        dow_o,
  output logic [7:0]        date_o,
  output logic [7:0]        month_o,
  output logic [7:0]        year_o,
  output logic              sec_strobe_o,
  output logic              sqw_1hz_o
);
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(NUM_REGS);

  rtc_time_t cur_q, nxt;
  logic      wr_fire, secs_wr, sec_end, strobe_q;

  assign wr_ready_o = 1'b1;
  assign wr_fire    = wr_valid_i && (wr_addr_i < MAP_END);
  assign secs_wr    = wr_fire && (wr_addr_i == ADDR_W'(A_SECS));

  rtc_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick_i (ref_tick_i),
    .restart_i  (secs_wr),
    .sec_end_o  (sec_end),
    .phase_hi_o (sqw_1hz_o)
  );

  rtc_time_advance u_adv (
    .cur_i (cur_q),
    .nxt_o (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= RESET_TIME;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= sec_end && !wr_fire;
      if (wr_fire) begin
        case (wr_addr_i)
          ADDR_W'(A_SECS): cur_q.secs <= wr_data_i & write_mask(A_SECS);
          ADDR_W'(A_MINS): cur_q.mins <= wr_data_i & write_mask(A_MINS);
          ADDR_W'(A_HRS):  cur_q.hrs  <= wr_data_i & write_mask(A_HRS);
          ADDR_W'(A_DOW):  cur_q.dow  <= wr_data_i & write_mask(A_DOW);
          ADDR_W'(A_DATE): cur_q.date <= wr_data_i & write_mask(A_DATE);
          ADDR_W'(A_MON):  cur_q.mon  <= wr_data_i & write_mask(A_MON);
          default:         cur_q.yr   <= wr_data_i & write_mask(A_YR);
        endcase
      end else if (sec_end) begin
        cur_q <= nxt;
      end
    end
  end

  assign sec_o        = cur_q.secs;
  assign min_o        = cur_q.mins;
  assign hour_o       = cur_q.hrs;
  assign dow_o        = cur_q.dow;
  assign date_o       = cur_q.date;
  assign month_o      = cur_q.mon;
  assign year_o       = cur_q.yr;
  assign sec_strobe_o = strobe_q;
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        sec_o,
  input logic [7:0]        min_o,
  input logic [7:0]        hour_o,
  input logic [7:0]        date_o,
  input logic [7:0]        month_o,
  input logic              sec_strobe_o,
  input logic              sqw_1hz_o
);
  logic mapped_wr, secs_wr;
  assign mapped_wr = wr_valid_i && (wr_addr_i < ADDR_W'(NUM_REGS));
  assign secs_wr   = wr_valid_i && (wr_addr_i == ADDR_W'(A_SECS));

  assert_sec_bcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[3:0] <= 4'd9) && (sec_o[7:4] <= 4'd5));

  assert_hour24_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hour_o[6] |-> (!hour_o[7] && hour_o[5:0] <= 6'h23 && hour_o[3:0] <= 4'd9));

  assert_hour12_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hour_o[6] |-> (!hour_o[7] && hour_o[4:0] != 5'h00 && hour_o[4:0] <= 5'h12 && hour_o[3:0] <= 4'd9));

  assert_date_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (date_o != 8'h00) && (date_o <= 8'h31) && (date_o[3:0] <= 4'd9));

  assert_month_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (month_o[4:0] != 5'h00) && (month_o[4:0] <= 5'h12) && (month_o[6:5] == 2'b00));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe_o |-> !$past(mapped_wr));

  assert_strobe_moves_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe_o |-> (sec_o != $past(sec_o)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_strobe_o && !$past(wr_valid_i)) |->
      ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o) && $stable(month_o)));

  assert_sqw_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(secs_wr) |-> !sqw_1hz_o);

  assert_ready_R13: assert property (@(posedge clk) disable iff (!rst_n) wr_ready_o);
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid_i   (wr_valid_i),
  .wr_ready_o   (wr_ready_o),
  .wr_addr_i    (wr_addr_i),
  .sec_o        (sec_o),
  .min_o        (min_o),
  .hour_o       (hour_o),
  .date_o       (date_o),
  .month_o      (month_o),
  .sec_strobe_o (sec_strobe_o),
  .sqw_1hz_o    (sqw_1hz_o)
);

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb;
  localparam int DIV = 8;
  localparam int AW  = 3;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, sec_strobe, sqw;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  always #2.5 clk = ~clk;

  rtc_bcd_calendar #(.DIV_COUNT(DIV), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .sec_strobe_o(sec_strobe), .sqw_1hz_o(sqw)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0, cmp_en = 0, gapped = 0;

  // behavioural model state: plain integers
  int m_sec, m_min, m_hr24, m_dow, m_date, m_mon, m_year, m_cnt;
  bit m_mode12, m_cent, m_strobe;

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] exp_hour();
    int h;
    if (!m_mode12) return to_bcd(m_hr24);
    h = m_hr24 % 12;
    if (h == 0) h = 12;
    return 8'h40 | ((m_hr24 >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
  endfunction

  function automatic void m_reset();
    m_sec = 0; m_min = 0; m_hr24 = 0; m_dow = 1; m_date = 1; m_mon = 1; m_year = 0;
    m_mode12 = 0; m_cent = 0; m_cnt = 0; m_strobe = 0;
  endfunction

  function automatic void m_advance();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr24++;
    if (m_hr24 < 24) return;
    m_hr24 = 0;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    m_date++;
    if (m_date <= days_in(m_mon, m_year)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_year++;
    if (m_year < 100) return;
    m_year = 0; m_cent = ~m_cent;
  endfunction

  function automatic void m_write(input int a, input logic [7:0] d);
    logic [7:0] v;
    int h;
    case (a)
      0: m_sec  = from_bcd(d & 8'h7F);
      1: m_min  = from_bcd(d & 8'h7F);
      2: begin
        v = d & 8'h7F;
        m_mode12 = v[6];
        if (v[6]) begin
          h = from_bcd(v & 8'h1F);
          m_hr24 = (h % 12) + (v[5] ? 12 : 0);
        end else m_hr24 = from_bcd(v & 8'h3F);
      end
      3: m_dow  = int'(d & 8'h07);
      4: m_date = from_bcd(d & 8'h3F);
      5: begin m_cent = d[7]; m_mon = from_bcd(d & 8'h1F); end
      default: m_year = from_bcd(d);
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_reset();
    else begin
      m_strobe = 0;
      if (wr_valid && int'(wr_addr) < 7) begin
        m_write(int'(wr_addr), wr_data);
        if (wr_addr == 0) m_cnt = 0;
        else if (ref_tick) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      end else if (ref_tick) begin
        if (m_cnt == DIV - 1) begin m_cnt = 0; m_advance(); m_strobe = 1; end
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) ref_tick <= gapped ? (cyc % 3 != 0) : 1'b1;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R2 seconds", sec_o, to_bcd(m_sec));
      chk("R2 minutes", min_o, to_bcd(m_min));
      chk(m_mode12 ? "R4 hour 12h" : "R3 hour 24h", hour_o, exp_hour());
      chk("R5 day of week", dow_o, 8'(m_dow));
      chk("R6 date", date_o, to_bcd(m_date));
      chk("R7 month", month_o, {m_cent, 7'b0} | to_bcd(m_mon));
      chk("R7 year", year_o, to_bcd(m_year));
      chk("R12 strobe", {7'b0, sec_strobe}, {7'b0, m_strobe});
      chk("R11 square wave", {7'b0, sqw}, {7'b0, (m_cnt >= DIV / 2)});
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
  endtask

  task automatic wait_strobes(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (sec_strobe !== 1'b1);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    int k, hi;
    logic [7:0] s_keep, m_keep, d_keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cmp_en = 1'b1;
    @(negedge clk);
    chk("R1 reset seconds", sec_o, 8'h00);
    chk("R1 reset hour", hour_o, 8'h00);
    chk("R1 reset dow", dow_o, 8'h01);
    chk("R1 reset date", date_o, 8'h01);
    chk("R1 reset month", month_o, 8'h01);
    chk("R1 reset year", year_o, 8'h00);
    chk("R1 reset strobe", {7'b0, sec_strobe}, 8'h00);
    chk("R13 ready", {7'b0, wr_ready}, 8'h01);

    gapped = 1'b1;
    // non-leap February end, 24-hour midnight, dow wrap
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    wait_strobes(2);
    chk("R3 midnight hour", hour_o, 8'h00);
    chk("R5 dow wrap", dow_o, 8'h01);
    chk("R6 feb28 nonleap date", date_o, 8'h01);
    chk("R6 feb28 nonleap month", month_o, 8'h03);
    // leap February
    set_time(8'h58, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    wait_strobes(2);
    chk("R6 leap feb29", date_o, 8'h29);
    set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    wait_strobes(2);
    chk("R6 leap end month", month_o, 8'h03);
    // 30-day month
    set_time(8'h58, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h23);
    wait_strobes(2);
    chk("R6 april end date", date_o, 8'h01);
    chk("R6 april end month", month_o, 8'h05);
    // century wrap both ways
    set_time(8'h58, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    wait_strobes(2);
    chk("R7 century set", month_o, 8'h81);
    chk("R7 year wrap", year_o, 8'h00);
    set_time(8'h58, 8'h59, 8'h23, 8'h05, 8'h31, 8'h92, 8'h99);
    wait_strobes(2);
    chk("R7 century clear", month_o, 8'h01);
    // 12-hour sequence
    set_time(8'h58, 8'h59, 8'h51, 8'h03, 8'h10, 8'h01, 8'h30);
    wait_strobes(2);
    chk("R4 11AM to 12PM", hour_o, 8'h72);
    chk("R4 noon keeps date", date_o, 8'h10);
    set_time(8'h58, 8'h59, 8'h72, 8'h03, 8'h10, 8'h01, 8'h30);
    wait_strobes(2);
    chk("R4 12PM to 1PM", hour_o, 8'h61);
    set_time(8'h58, 8'h59, 8'h71, 8'h03, 8'h10, 8'h01, 8'h30);
    wait_strobes(2);
    chk("R4 11PM to 12AM", hour_o, 8'h52);
    chk("R4 midnight date", date_o, 8'h11);
    chk("R5 midnight dow", dow_o, 8'h04);
    wait_strobes(3);

    gapped = 1'b0;
    repeat (3) @(negedge clk);
    // masks and unmapped address
    wr(0, 8'hD9);
    chk("R8 seconds mask", sec_o, 8'h59);
    wr(3, 8'hFF);
    chk("R8 dow mask", dow_o, 8'h07);
    m_keep = min_o; d_keep = date_o;
    wr(7, 8'h00);
    chk("R8 unmapped minutes", min_o, m_keep);
    chk("R8 unmapped date", date_o, d_keep);
    wait_strobes(1);

    // write landing on the cycle a second ends
    while (m_cnt != DIV - 1) @(negedge clk);
    s_keep = sec_o;
    wr(1, 8'h30);
    chk("R9 seconds held", sec_o, s_keep);
    chk("R9 no strobe", {7'b0, sec_strobe}, 8'h00);
    chk("R8 minutes written", min_o, 8'h30);

    // divider restart and square-wave phase
    repeat (2) @(negedge clk);
    wr(0, 8'h10);
    chk("R11 low after write", {7'b0, sqw}, 8'h00);
    k = 0; hi = 0;
    while (sec_strobe !== 1'b1 && k < 4 * DIV) begin
      if (sqw) hi++;
      @(negedge clk);
      k++;
    end
    chk("R10 restart spacing", 8'(k), 8'(DIV));
    chk("R11 high half", 8'(hi), 8'(DIV / 2));
    chk("R10 seconds after restart", sec_o, 8'h11);
    @(negedge clk);
    chk("R12 strobe one cycle", {7'b0, sec_strobe}, 8'h00);
    chk("R13 ready late", {7'b0, wr_ready}, 8'h01);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (R12 progress): actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule